// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

A 32-bit timer that sits on a simple word-addressed register bus. A down-counter advances once per tick, where a tick is produced by dividing one of three external tick-enable streams by a programmable ratio. When the counter passes zero it either reloads from a programmed value or rolls over to all-ones. Each time the counter lands on the programmed compare value, a sticky flag is raised, and it can drive a level interrupt.

Software programs the control word, then uses the load, compare and status registers to set the period and service events. It can read the live count at any time. A self-clearing soft-reset bit returns most of the state to its reset values but keeps the enable bit and the low-power policy bits.

Top module: `prd_timer`

## Requirements
- R1: Word offsets are 0 control, 1 status, 2 load, 3 compare, 4 live counter (read only). Any other offset reads zero and a write there changes nothing. After reset: control 0, status 0, load 0xFFFFFFFF, compare 0, counter 0, irq low.
- R2: Control bits: 0 run enable, 1 init-on-enable, 2 compare interrupt enable, 3 reload mode, 15:4 divider N, 16 soft reset, 17 immediate overwrite, 18 to 21 low-power policy bits (stored only), 25:24 source select. Bits 31:26 and bit 16 always read 0.
- R3: Source select 00 gives no ticks; 01, 10 and 11 pick the inputs tick_main, tick_fast and tick_slow.
- R4: With divider N, one counter tick happens on every (N+1)-th selected source pulse while run enable is set. A change of divider or source select restarts the division from zero, and that cycle yields no tick.
- R5: On each tick the counter decrements by one. At a tick with the counter at 0 it becomes the load value when reload mode (bit 3) is set, else 0xFFFFFFFF.
- R6: A control write that takes run enable from 0 to 1 with bit 1 set loads the counter with the load value if the written bit 3 is set, else 0xFFFFFFFF. With bit 1 clear the counter keeps its value.
- R7: A load-register write while bit 17 is set also writes the counter with the same value, in either reload mode. Without bit 17 the counter is not changed.
- R8: Status bit 0 sets when a tick makes the counter equal to the compare value. Writing status with bit 0 = 1 clears it; bit 0 = 0 has no effect. A set in the same cycle as a clear wins.
- R9: irq is high exactly when status bit 0, control bit 2 and control bit 0 are all set.
- R10: With run enable clear the counter holds and no compare event occurs.
- R11: A control write with bit 16 set stores only bits 0, 1 and 18 to 21 of the written value, clears status and compare and the counter, and sets load to 0xFFFFFFFF.
- R12: A bus action that writes the counter (soft reset, init-on-enable, immediate overwrite) wins over a tick in the same cycle; that tick is dropped and does not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| tick_main | input | 1 | Source 1 tick enable |
| tick_fast | input | 1 | Source 2 tick enable |
| tick_slow | input | 1 | Source 3 tick enable |
| irq | output | 1 | Level compare interrupt |

## Verification
Two pairs of functions can meet in a single cycle: the compare event setting the flag while software writes 1 to clear it, and a tick decrementing the counter while a bus write replaces the counter. The bench provokes the first by writing the status clear on consecutive cycles while the counter sweeps through the compare value, and the second by performing immediate-overwrite load writes and enable-with-init writes while the selected source pulses every cycle. A behavioural model, updated on every edge with the same inputs, predicts the read data for the addressed word and the interrupt, and both are compared on every clock, so set-wins and write-wins ordering is judged cycle by cycle.

// File: rtl/prd_timer_pkg.sv
package prd_timer_pkg;
   localparam int CTRL_W   = 26;
   localparam int B_EN     = 0;
   localparam int B_INIT   = 1;
   localparam int B_CIE    = 2;
   localparam int B_RLD    = 3;
   localparam int B_DIV_LO = 4;
   localparam int B_SRST   = 16;
   localparam int B_OVW    = 17;
   localparam int B_PW_LO  = 18;
   localparam int B_PW_HI  = 21;
   localparam int B_SRC_LO = 24;
   localparam int SRC_W    = 2;
   localparam int NUM_SRC  = 1 << SRC_W;

   typedef enum logic [2:0] {
      OFS_CTRL = 3'd0,
      OFS_STAT = 3'd1,
      OFS_LOAD = 3'd2,
      OFS_CMP  = 3'd3,
      OFS_CNT  = 3'd4
   } ofs_e;

   function automatic logic [CTRL_W-1:0] keep_mask();
      logic [CTRL_W-1:0] m;
      m = '0;
      m[B_EN]   = 1'b1;
      m[B_INIT] = 1'b1;
      for (int i = B_PW_LO; i <= B_PW_HI; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/prd_timer_presc.sv
module prd_timer_presc #(
   parameter int PSC_W = 12,
   parameter int CFG_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             src_tick,
   input  logic [PSC_W-1:0] div,
   input  logic [CFG_W-1:0] cfg,
   output logic             tick
);
   logic [PSC_W-1:0] pc_q;
   logic [CFG_W-1:0] cfg_q;
   logic             cfg_chg;

   assign cfg_chg = (cfg != cfg_q);
   assign tick    = run && src_tick && !cfg_chg && (pc_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         cfg_q <= '0;
      end else begin
         cfg_q <= cfg;
         if (cfg_chg)
            pc_q <= '0;
         else if (run && src_tick)
            pc_q <= (pc_q == div) ? '0 : pc_q + 1'b1;
      end
   end

   p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pc_q == '0));
   p_cfg_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> (pc_q == '0));
endmodule

// File: rtl/prd_timer_core.sv
module prd_timer_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             rld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             init_req,
   input  logic [CNT_W-1:0] init_val,
   input  logic             srst,
   input  logic             clr_req,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);
   localparam logic [CNT_W-1:0] ALL1 = '1;

   logic [CNT_W-1:0] nxt;
   logic             step;
   logic             hit;

   assign step = tick && !init_req;
   assign nxt  = (cnt == '0) ? (rld ? ld_val : ALL1) : cnt - 1'b1;
   assign hit  = step && (nxt == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (init_req)
            cnt <= init_val;
         else if (tick)
            cnt <= nxt;
         if (srst)
            flag <= 1'b0;
         else if (hit)
            flag <= 1'b1;
         else if (clr_req)
            flag <= 1'b0;
      end
   end

   p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !init_req) |=> $stable(cnt));
   p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !init_req && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   p_wrap_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !init_req && cnt == '0 && !rld) |=> (cnt == ALL1));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !tick) |=> !flag);
   p_no_event_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !flag) |=> !flag);
endmodule

// File: rtl/prd_timer.sv
module prd_timer #(
   parameter int DATA_W = 32,
   parameter int AW     = 3,
   parameter int PSC_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_main,
   input  logic              tick_fast,
   input  logic              tick_slow,
   output logic              irq
);
   import prd_timer_pkg::*;

   localparam int CFG_W = SRC_W + PSC_W;
   localparam logic [DATA_W-1:0] ALL1 = '1;
   localparam logic [CTRL_W-1:0] KEEP = keep_mask();
   localparam logic [CTRL_W-1:0] NO_SRST = ~(CTRL_W'(1) << B_SRST);

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("DATA_W must hold the control word");
      end
      if (AW < 3) begin : g_bad_addr
         $error("AW must reach offset 4");
      end
      if (B_DIV_LO + PSC_W > B_SRST) begin : g_bad_div
         $error("divider field overlaps soft reset bit");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] load_q, cmp_q, cnt, init_val;
   logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
   logic              srst, en_rise, init_req, flag, ptick;
   logic [SRC_W-1:0]  src_sel;
   logic [PSC_W-1:0]  div;
   logic [NUM_SRC-1:0] src_vec;

   assign wr_ctrl = bus_we && (bus_addr == AW'(OFS_CTRL));
   assign wr_stat = bus_we && (bus_addr == AW'(OFS_STAT));
   assign wr_load = bus_we && (bus_addr == AW'(OFS_LOAD));
   assign wr_cmp  = bus_we && (bus_addr == AW'(OFS_CMP));

   assign srst    = wr_ctrl && bus_wdata[B_SRST];
   assign en_rise = wr_ctrl && !srst && !ctrl_q[B_EN]
                    && bus_wdata[B_EN] && bus_wdata[B_INIT];
   assign init_req = srst || en_rise || (wr_load && ctrl_q[B_OVW]);

   always_comb begin
      if (srst)
         init_val = '0;
      else if (en_rise)
         init_val = bus_wdata[B_RLD] ? load_q : ALL1;
      else
         init_val = bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= ALL1;
         cmp_q  <= '0;
      end else if (srst) begin
         ctrl_q <= bus_wdata[CTRL_W-1:0] & KEEP;
         load_q <= ALL1;
         cmp_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0] & NO_SRST;
         if (wr_load) load_q <= bus_wdata;
         if (wr_cmp)  cmp_q  <= bus_wdata;
      end
   end

   assign src_sel = ctrl_q[B_SRC_LO +: SRC_W];
   assign div     = ctrl_q[B_DIV_LO +: PSC_W];

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         if (g == 0) begin : g_off
            assign src_vec[g] = 1'b0;
         end else if (g == 1) begin : g_main
            assign src_vec[g] = tick_main;
         end else if (g == 2) begin : g_fast
            assign src_vec[g] = tick_fast;
         end else begin : g_slow
            assign src_vec[g] = tick_slow;
         end
      end
   endgenerate

   prd_timer_presc #(.PSC_W(PSC_W), .CFG_W(CFG_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q[B_EN]),
      .src_tick (src_vec[src_sel]),
      .div      (div),
      .cfg      ({src_sel, div}),
      .tick     (ptick)
   );

   prd_timer_core #(.CNT_W(DATA_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ptick),
      .run      (ctrl_q[B_EN]),
      .rld      (ctrl_q[B_RLD]),
      .ld_val   (load_q),
      .cmp_val  (cmp_q),
      .init_req (init_req),
      .init_val (init_val),
      .srst     (srst),
      .clr_req  (wr_stat && bus_wdata[0]),
      .cnt      (cnt),
      .flag     (flag)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(OFS_CTRL): bus_rdata = DATA_W'(ctrl_q);
         AW'(OFS_STAT): bus_rdata = DATA_W'(flag);
         AW'(OFS_LOAD): bus_rdata = load_q;
         AW'(OFS_CMP):  bus_rdata = cmp_q;
         AW'(OFS_CNT):  bus_rdata = cnt;
         default:       bus_rdata = '0;
      endcase
   end

   assign irq = flag && ctrl_q[B_CIE] && ctrl_q[B_EN];

   p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
   p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(OFS_CTRL)) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0 && !bus_rdata[B_SRST]));
   p_srst_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (load_q == ALL1 && cmp_q == '0 && cnt == '0 && !flag));
   p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_load && ctrl_q[B_OVW]) |=> (cnt == $past(bus_wdata)));
endmodule

// File: tb/prd_timer_bench.sv
module prd_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        tick_main = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string req = "R1";

   // reference state
   logic [25:0] m_ctrl = '0;
   logic        m_flag = 0;
   logic [31:0] m_load = 32'hFFFF_FFFF, m_cmp = 0, m_cnt = 0;
   int          m_pc = 0;
   logic [13:0] m_cfgq = '0;

   always #2.5 clk = ~clk;

   prd_timer u_prd_timer (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_main(tick_main),
      .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
   );

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {6'd0, m_ctrl};
         3'd1: return {31'd0, m_flag};
         3'd2: return m_load;
         3'd3: return m_cmp;
         3'd4: return m_cnt;
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h at %0t", r, got, exp, $time);
      end
   endtask

   // behavioural model, one step per edge
   always @(posedge clk) begin
      if (rst_n) begin
         logic [25:0] oc;
         logic [31:0] ol, ocmp, ocnt, nv;
         logic [13:0] cfg;
         bit src, tk, wcnt, clr, sethit, sr;
         oc = m_ctrl; ol = m_load; ocmp = m_cmp; ocnt = m_cnt;
         cfg = {oc[25:24], oc[15:4]};
         case (oc[25:24])
            2'd0: src = 0;
            2'd1: src = tick_main;
            2'd2: src = tick_fast;
            default: src = tick_slow;
         endcase
         tk = 0;
         if (cfg != m_cfgq) m_pc = 0;
         else if (oc[0] && src) begin
            if (m_pc == int'(oc[15:4])) begin m_pc = 0; tk = 1; end
            else m_pc++;
         end
         m_cfgq = cfg;
         wcnt = 0; clr = 0; sr = 0; sethit = 0;
         if (bus_we) begin
            case (bus_addr)
               3'd0: if (bus_wdata[16]) begin
                     sr = 1; wcnt = 1;
                     m_ctrl = bus_wdata[25:0] & 26'h03C_0003;
                     m_load = 32'hFFFF_FFFF; m_cmp = 0; m_cnt = 0;
                  end else begin
                     m_ctrl = bus_wdata[25:0] & ~26'h001_0000;
                     if (!oc[0] && bus_wdata[0] && bus_wdata[1]) begin
                        wcnt = 1;
                        m_cnt = bus_wdata[3] ? ol : 32'hFFFF_FFFF;
                     end
                  end
               3'd1: clr = bus_wdata[0];
               3'd2: begin
                  m_load = bus_wdata;
                  if (oc[17]) begin wcnt = 1; m_cnt = bus_wdata; end
               end
               3'd3: m_cmp = bus_wdata;
               default: ;
            endcase
         end
         if (tk && !wcnt) begin
            nv = (ocnt == 0) ? (oc[3] ? ol : 32'hFFFF_FFFF) : ocnt - 1;
            m_cnt = nv;
            sethit = (nv == ocmp);
         end
         if (sr) m_flag = 0;
         else if (sethit) m_flag = 1;
         else if (clr) m_flag = 0;
      end
   end

   // compare on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({req, " rdata"}, bus_rdata, m_read(bus_addr));
         chk({req, " irq R9"}, {31'd0, irq},
             {31'd0, m_flag && m_ctrl[2] && m_ctrl[0]});
      end
   end

   // tick source patterns
   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk); #1;
         cyc++;
         tick_main = (cyc % 2 == 0);
         tick_fast = 1'b1;
         tick_slow = (cyc % 5 == 0);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string r);
      @(posedge clk); #1;
      bus_we = 0; bus_addr = a;
      #1 chk(r, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] frozen;
      idle(3); #1 rst_n = 1;
      // R1 reset values and map
      req = "R1";
      chk("R1 irq reset", {31'd0, irq}, 32'd0);
      rd(3'd0, 32'd0, "R1 ctrl reset");
      rd(3'd1, 32'd0, "R1 stat reset");
      rd(3'd2, 32'hFFFF_FFFF, "R1 load reset");
      rd(3'd3, 32'd0, "R1 cmp reset");
      rd(3'd4, 32'd0, "R1 cnt reset");
      rd(3'd5, 32'd0, "R1 unmapped read");
      wr(3'd6, 32'h1234_5678);
      rd(3'd2, 32'hFFFF_FFFF, "R1 unmapped write no effect");
      rd(3'd7, 32'd0, "R1 unmapped read 7");

      // R2 control masking
      req = "R2";
      wr(3'd0, 32'hFC0E_FFF0);
      rd(3'd0, 32'h000E_FFF0, "R2 ctrl readback");

      // R7 immediate overwrite (bit 17 set above)
      req = "R7";
      wr(3'd2, 32'h0000_0100);
      rd(3'd4, 32'h0000_0100, "R7 overwrite");
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h0000_0050);
      rd(3'd4, 32'h0000_0100, "R7 no overwrite");

      // R6 init-on-enable with reload, R5 reload at zero, R3 main source
      req = "R6";
      wr(3'd0, 32'h0100_000B);
      req = "R5";
      idle(220);
      // R10 freeze
      req = "R10";
      wr(3'd0, 32'h0100_0008);
      bus_addr = 3'd4; idle(2); #1 frozen = bus_rdata;
      idle(10);
      rd(3'd4, frozen, "R10 frozen count");
      // R6 resume without init, source off
      req = "R6";
      wr(3'd0, 32'h0000_0001);
      rd(3'd4, frozen, "R6 resume keeps count");

      // R5 free-running wrap, R12 overwrite vs every-cycle tick, R3 fast source
      req = "R12";
      wr(3'd0, 32'h0202_0001);
      wr(3'd2, 32'h0000_0005);
      req = "R5";
      idle(12);
      req = "R12";
      wr(3'd2, 32'h0000_0003);
      wr(3'd0, 32'h0);
      wr(3'd0, 32'h0200_000B);
      idle(4);

      // R4 divider on slow source, with a mid-run divider change
      req = "R4";
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h0000_0040);
      wr(3'd0, 32'h0300_003B);
      idle(80);
      wr(3'd0, 32'h0300_001B);
      idle(60);
      wr(3'd0, 32'h0100_002B);
      idle(40);

      // R8 compare flag, R9 interrupt, set-vs-clear collision
      req = "R8";
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h0000_0020);
      wr(3'd3, 32'h0000_0010);
      wr(3'd0, 32'h0200_000F);
      idle(30);
      req = "R9";
      wr(3'd1, 32'h0000_0000);
      idle(3);
      req = "R8";
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #1 bus_we = 1; bus_addr = 3'd1; bus_wdata = 32'h1;
      end
      @(posedge clk); #1 bus_we = 0;
      idle(40);
      req = "R9";
      wr(3'd0, 32'h0200_000B);
      idle(40);
      wr(3'd0, 32'h0200_000F);
      idle(20);
      wr(3'd1, 32'h1);
      idle(5);

      // R11 soft reset
      req = "R11";
      wr(3'd3, 32'h0000_0007);
      wr(3'd0, 32'h013D_000F);
      rd(3'd0, 32'h003C_0003, "R11 ctrl kept bits");
      rd(3'd1, 32'd0, "R11 status cleared");
      rd(3'd2, 32'hFFFF_FFFF, "R11 load set");
      rd(3'd3, 32'd0, "R11 cmp cleared");
      rd(3'd4, 32'd0, "R11 cnt cleared");
      idle(5);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule